// File: doc/BRIEF.md
# Legacy Memory Region Attribute Decoder

This block is the slice of a host bridge that decides where accesses to the legacy low-memory areas go. It holds seven attribute bytes that cover thirteen legacy segments: the 64 KB boot firmware area at 0xF0000–0xFFFFF and twelve 16 KB expansion segments at 0xC0000–0xEFFFF. It also holds a control byte for the 0xA0000–0xBFFFF system-management window and a read-only byte that reports installed memory size. Software reaches all of these through byte-enabled, dword-indexed configuration writes and combinational configuration reads.

From the stored bytes the block drives per-segment read and write steering flags and two window flags. A lookup port takes an address and a system-management-mode flag and tells, for that access, whether a read and whether a write would land in DRAM (1) or be forwarded to PCI (0). The window control byte has a seal: a two-state machine with states `LK_UNSEALED` and `LK_SEALED`. Its only transition, UNSEALED to SEALED, fires on a write to offset 0x72 with bit 4 set. SEALED is left only by reset.

Top module: `legacy_route_ctl`

## Requirements
- R1: After reset every attribute byte is 0, so all 13 segment flags read 0 (PCI). Offset 0x72 reads 0x02, `win_pci_alias` is 1 and `win_smm_dram` is 0.
- R2: Segment i is steered by the byte at offset 0x59 + ceil(i/2). Segment 0 (0xF0000–0xFFFFF) uses bits 5:4 of 0x59. An odd segment uses the low nibble of its byte and an even segment from 2 up uses the high nibble. Within the chosen pair, the lower bit enables reads to DRAM and the upper bit enables writes to DRAM.
- R3: `cfg_dw_addr` selects offsets 4*idx to 4*idx+3. Lane k carries `cfg_wdata[8k+7:8k]` and is written only when `cfg_be[k]` is 1. `cfg_rdata` returns all four bytes, and unimplemented offsets read 0.
- R4: Routing outputs change only after a write that touches 0x59–0x5F or 0x72. The new value shows on every output together, starting in the cycle after the write edge. A lookup in the write cycle itself still sees the old value.
- R5: Offset 0x72 layout: bit 6 open, bit 5 close, bit 4 lock, bit 3 global enable, bits 2:0 read 010, bit 7 reads 0.
- R6: A write to 0x72 with bit 4 set seals the byte, and that same write stores open = 0. While sealed, the open bit reads 0 and cannot be set, and lock stays 1 until reset. The close bit and the global enable bit stay writable.
- R7: For a non-SMM access to 0xA0000–0xBFFFF, reads and writes go to DRAM only when open = 1. Otherwise they go to PCI, and `win_pci_alias` equals the inverse of open.
- R8: For an SMM access to 0xA0000–0xBFFFF, reads and writes go to DRAM only when global enable = 1. `win_smm_dram` mirrors that bit.
- R9: An address in 0xC0000–0xEFFFF uses segment 1 + (addr − 0xC0000)/16 KB, and 0xF0000–0xFFFFF uses segment 0. Addresses below 0xA0000 or at 0x100000 and above go to DRAM for both directions.
- R10: Offset 0x57 reads min(`dram_mb`/8, 255) and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_dw_addr | input | 6 | Dword index of the configuration offset |
| cfg_be | input | 4 | Byte-lane enables for writes |
| cfg_wdata | input | 32 | Write data, lane k in bits 8k+7:8k |
| cfg_rdata | output | 32 | Read data for the selected dword |
| dram_mb | input | SIZE_W | Installed memory size in MB |
| seg_rd_dram | output | 13 | Per-segment read steering, 1 = DRAM |
| seg_wr_dram | output | 13 | Per-segment write steering, 1 = DRAM |
| win_pci_alias | output | 1 | Non-SMM window accesses forwarded to PCI |
| win_smm_dram | output | 1 | SMM window accesses reach DRAM |
| acc_addr | input | ADDR_W | Lookup address |
| acc_smm | input | 1 | Lookup requester is in SMM |
| acc_rd_dram | output | 1 | A read at the lookup address goes to DRAM |
| acc_wr_dram | output | 1 | A write at the lookup address goes to DRAM |

## Verification
Two functions can fall in the same cycle: a lookup on the address port, and a configuration write that rewrites the byte steering that address. The bench holds a lookup address in segment 1 and issues a write that flips that segment's nibble. It samples `acc_rd_dram` while the write strobe is still high, before the edge, and expects the old value. It samples again one cycle later and expects the new value. A second collision is a single write that carries both the lock and open bits. The expected result is that the seal wins, judged by reading back 0x72 and by the window outputs.

// File: rtl/lrd_pkg.sv
package lrd_pkg;
    localparam int SEG_CNT    = 13;
    localparam int ATTR_CNT   = 7;
    localparam int ATTR_BITS  = ATTR_CNT * 8;

    localparam logic [7:0] ATTR_BASE  = 8'h59;
    localparam logic [7:0] ATTR_LAST  = 8'h59 + 8'(ATTR_CNT - 1);
    localparam logic [7:0] SMRAM_OFS  = 8'h72;
    localparam logic [7:0] SIZE_OFS   = 8'h57;

    localparam int B_OPEN  = 6;
    localparam int B_CLOSE = 5;
    localparam int B_LOCK  = 4;
    localparam int B_GEN   = 3;
    localparam logic [2:0] SEG_BASE_CODE = 3'b010;

    localparam logic [31:0] WIN_LO  = 32'h000A_0000;
    localparam logic [31:0] EXP_LO  = 32'h000C_0000;
    localparam logic [31:0] BIOS_LO = 32'h000F_0000;
    localparam logic [31:0] TOP_LO  = 32'h0010_0000;

    typedef enum logic {
        LK_UNSEALED = 1'b0,
        LK_SEALED   = 1'b1
    } seal_t;
endpackage

// File: rtl/lrd_cfg_regs.sv
module lrd_cfg_regs
    import lrd_pkg::*;
#(
    parameter int SIZE_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [5:0]           cfg_dw_addr,
    input  logic [3:0]           cfg_be,
    input  logic [31:0]          cfg_wdata,
    output logic [31:0]          cfg_rdata,
    input  logic [SIZE_W-1:0]    dram_mb,
    output logic [ATTR_BITS-1:0] attr_flat,
    output logic                 smram_open,
    output logic                 smram_gen
);
    localparam int SM_DW   = int'(SMRAM_OFS) / 4;
    localparam int SM_LANE = int'(SMRAM_OFS) % 4;

    logic [7:0]  attr_q [ATTR_CNT];
    logic        open_q, close_q, gen_q;
    seal_t       seal_q, seal_d;
    logic        sealed;
    logic        sm_wr;
    logic [7:0]  sm_byte;
    logic [7:0]  size_byte;
    logic [SIZE_W-1:0] size_units;
    logic        unused_size_low;

    // Attribute bytes: one register per byte, lane decoded from its offset
    for (genvar j = 0; j < ATTR_CNT; j++) begin : g_attr
        localparam int OFS  = int'(ATTR_BASE) + j;
        localparam int DW   = OFS / 4;
        localparam int LANE = OFS % 4;
        logic hit;
        assign hit = cfg_we && (cfg_dw_addr == 6'(DW)) && cfg_be[LANE];
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   attr_q[j] <= 8'h00;
            else if (hit) attr_q[j] <= cfg_wdata[8*LANE +: 8];
        end
        assign attr_flat[8*j +: 8] = attr_q[j];
    end

    assign sm_wr   = cfg_we && (cfg_dw_addr == 6'(SM_DW)) && cfg_be[SM_LANE];
    assign sm_byte = cfg_wdata[8*SM_LANE +: 8];

    // Seal state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seal_q <= LK_UNSEALED;
        else        seal_q <= seal_d;
    end

    // Seal next state
    always_comb begin
        seal_d = seal_q;
        unique case (seal_q)
            LK_UNSEALED: if (sm_wr && sm_byte[B_LOCK]) seal_d = LK_SEALED;
            LK_SEALED:   seal_d = LK_SEALED;
        endcase
    end

    // Seal output
    always_comb sealed = (seal_q == LK_SEALED);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            open_q  <= 1'b0;
            close_q <= 1'b0;
            gen_q   <= 1'b0;
        end else if (sm_wr) begin
            open_q  <= sm_byte[B_OPEN] && !sm_byte[B_LOCK] && !sealed;
            close_q <= sm_byte[B_CLOSE];
            gen_q   <= sm_byte[B_GEN];
        end
    end

    assign smram_open = open_q;
    assign smram_gen  = gen_q;

    // Size byte: 8 MB units, saturating
    assign size_units      = dram_mb >> 3;
    assign size_byte       = (size_units > SIZE_W'(255)) ? 8'hFF : size_units[7:0];
    assign unused_size_low = ^dram_mb[2:0];

    // Read mux
    always_comb begin
        cfg_rdata = '0;
        for (int k = 0; k < 4; k++) begin
            logic [7:0] ofs;
            logic [7:0] rb;
            ofs = {cfg_dw_addr, 2'(k)};
            rb  = 8'h00;
            if (ofs == SIZE_OFS)
                rb = size_byte;
            else if (ofs == SMRAM_OFS)
                rb = {1'b0, open_q, close_q, sealed, gen_q, SEG_BASE_CODE};
            else if (ofs >= ATTR_BASE && ofs <= ATTR_LAST)
                rb = attr_q[3'(ofs - ATTR_BASE)];
            cfg_rdata[8*k +: 8] = rb;
        end
    end
endmodule

// File: rtl/lrd_seg_map.sv
module lrd_seg_map
    import lrd_pkg::*;
(
    input  logic [ATTR_BITS-1:0] attr_flat,
    output logic [SEG_CNT-1:0]   seg_rd,
    output logic [SEG_CNT-1:0]   seg_wr
);
    logic unused_attr;

    for (genvar i = 0; i < SEG_CNT; i++) begin : g_seg
        localparam int BYTE_IX = (i + 1) / 2;
        localparam int NIB_LO  = ((i % 2) == 1) ? 0 : 4;
        assign seg_rd[i] = attr_flat[8*BYTE_IX + NIB_LO];
        assign seg_wr[i] = attr_flat[8*BYTE_IX + NIB_LO + 1];
    end

    assign unused_attr = ^attr_flat;
endmodule

// File: rtl/lrd_addr_route.sv
module lrd_addr_route
    import lrd_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0]  acc_addr,
    input  logic               acc_smm,
    input  logic [SEG_CNT-1:0] seg_rd,
    input  logic [SEG_CNT-1:0] seg_wr,
    input  logic               smram_open,
    input  logic               smram_gen,
    output logic               rd_dram,
    output logic               wr_dram
);
    localparam logic [ADDR_W-1:0] A_WIN  = ADDR_W'(WIN_LO);
    localparam logic [ADDR_W-1:0] A_EXP  = ADDR_W'(EXP_LO);
    localparam logic [ADDR_W-1:0] A_BIOS = ADDR_W'(BIOS_LO);
    localparam logic [ADDR_W-1:0] A_TOP  = ADDR_W'(TOP_LO);

    logic [ADDR_W-1:0] off;
    logic [3:0]        sidx;
    logic              unused_off;

    assign off        = acc_addr - A_EXP;
    assign sidx       = off[17:14] + 4'd1;
    assign unused_off = ^{off[ADDR_W-1:18], off[13:0]};

    always_comb begin
        rd_dram = 1'b1;
        wr_dram = 1'b1;
        if (acc_addr < A_WIN) begin
            rd_dram = 1'b1;
            wr_dram = 1'b1;
        end else if (acc_addr < A_EXP) begin
            rd_dram = acc_smm ? smram_gen : smram_open;
            wr_dram = acc_smm ? smram_gen : smram_open;
        end else if (acc_addr < A_BIOS) begin
            rd_dram = seg_rd[sidx];
            wr_dram = seg_wr[sidx];
        end else if (acc_addr < A_TOP) begin
            rd_dram = seg_rd[0];
            wr_dram = seg_wr[0];
        end
    end
endmodule

// File: rtl/legacy_route_ctl.sv
module legacy_route_ctl
    import lrd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [5:0]        cfg_dw_addr,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic [SIZE_W-1:0] dram_mb,
    output logic [12:0]       seg_rd_dram,
    output logic [12:0]       seg_wr_dram,
    output logic              win_pci_alias,
    output logic              win_smm_dram,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_smm,
    output logic              acc_rd_dram,
    output logic              acc_wr_dram
);
    logic [ATTR_BITS-1:0] attr_flat;
    logic                 smram_open, smram_gen;
    logic [SEG_CNT-1:0]   seg_rd, seg_wr;

    lrd_cfg_regs #(.SIZE_W(SIZE_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_dw_addr(cfg_dw_addr),
        .cfg_be     (cfg_be),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .dram_mb    (dram_mb),
        .attr_flat  (attr_flat),
        .smram_open (smram_open),
        .smram_gen  (smram_gen)
    );

    lrd_seg_map u_map (
        .attr_flat(attr_flat),
        .seg_rd   (seg_rd),
        .seg_wr   (seg_wr)
    );

    lrd_addr_route #(.ADDR_W(ADDR_W)) u_route (
        .acc_addr  (acc_addr),
        .acc_smm   (acc_smm),
        .seg_rd    (seg_rd),
        .seg_wr    (seg_wr),
        .smram_open(smram_open),
        .smram_gen (smram_gen),
        .rd_dram   (acc_rd_dram),
        .wr_dram   (acc_wr_dram)
    );

    assign seg_rd_dram   = seg_rd;
    assign seg_wr_dram   = seg_wr;
    assign win_pci_alias = !smram_open;
    assign win_smm_dram  = smram_gen;
endmodule

// File: rtl/lrd_checker.sv
module lrd_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [5:0]        cfg_dw_addr,
    input logic [12:0]       seg_rd_dram,
    input logic [12:0]       seg_wr_dram,
    input logic              win_pci_alias,
    input logic              win_smm_dram,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              acc_smm,
    input logic              acc_rd_dram,
    input logic              acc_wr_dram
);
    logic routing_wr;
    logic in_low, in_win, in_bios;

    assign routing_wr = cfg_we && (cfg_dw_addr == 6'h16 || cfg_dw_addr == 6'h17 ||
                                   cfg_dw_addr == 6'h1C);
    assign in_low  = acc_addr < ADDR_W'(32'h000A_0000);
    assign in_win  = !in_low && acc_addr < ADDR_W'(32'h000C_0000);
    assign in_bios = acc_addr >= ADDR_W'(32'h000F_0000) && acc_addr < ADDR_W'(32'h0010_0000);

    // R4
    p_quiet_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !routing_wr |=> ($stable(seg_rd_dram) && $stable(seg_wr_dram) &&
                         $stable(win_pci_alias) && $stable(win_smm_dram)));

    // R9
    p_low_dram_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_low |-> (acc_rd_dram && acc_wr_dram));

    // R7
    p_win_user_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_win && !acc_smm) |-> (acc_rd_dram == !win_pci_alias && acc_wr_dram == !win_pci_alias));

    // R8
    p_win_smm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_win && acc_smm) |-> (acc_rd_dram == win_smm_dram && acc_wr_dram == win_smm_dram));

    // R2
    p_bios_seg_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_bios |-> (acc_rd_dram == seg_rd_dram[0] && acc_wr_dram == seg_wr_dram[0]));
endmodule

bind legacy_route_ctl lrd_checker #(.ADDR_W(ADDR_W)) u_lrd_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_dw_addr  (cfg_dw_addr),
    .seg_rd_dram  (seg_rd_dram),
    .seg_wr_dram  (seg_wr_dram),
    .win_pci_alias(win_pci_alias),
    .win_smm_dram (win_smm_dram),
    .acc_addr     (acc_addr),
    .acc_smm      (acc_smm),
    .acc_rd_dram  (acc_rd_dram),
    .acc_wr_dram  (acc_wr_dram)
);

// File: tb/legacy_route_ctl_bench.sv
`timescale 1ns/1ps
module legacy_route_ctl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_dw_addr = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [15:0] dram_mb = 16'd512;
    logic [12:0] seg_rd_dram, seg_wr_dram;
    logic        win_pci_alias, win_smm_dram;
    logic [31:0] acc_addr = '0;
    logic        acc_smm = 1'b0;
    logic        acc_rd_dram, acc_wr_dram;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [7:0] m_attr [7];
    logic m_open = 0, m_close = 0, m_lock = 0, m_gen = 0;

    always #2.5 clk = ~clk;

    legacy_route_ctl u_legacy_route_ctl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_dw_addr(cfg_dw_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .dram_mb(dram_mb), .seg_rd_dram(seg_rd_dram), .seg_wr_dram(seg_wr_dram),
        .win_pci_alias(win_pci_alias), .win_smm_dram(win_smm_dram),
        .acc_addr(acc_addr), .acc_smm(acc_smm),
        .acc_rd_dram(acc_rd_dram), .acc_wr_dram(acc_wr_dram)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] m_sm_byte();
        return {1'b0, m_open, m_close, m_lock, m_gen, 3'b010};
    endfunction

    function automatic logic [1:0] m_nib(input int i);
        logic [7:0] b;
        b = m_attr[(i + 1) / 2];
        return ((i % 2) == 1) ? b[1:0] : b[5:4];
    endfunction

    function automatic logic [1:0] m_route(input logic [31:0] a, input logic smm);
        logic en;
        if (a < 32'hA0000 || a >= 32'h100000) return 2'b11;
        if (a < 32'hC0000) begin
            en = smm ? m_gen : m_open;
            return {en, en};
        end
        if (a >= 32'hF0000) return {m_nib(0)[1], m_nib(0)[0]};
        return {m_nib(1 + int'((a - 32'hC0000) >> 14))[1], m_nib(1 + int'((a - 32'hC0000) >> 14))[0]};
    endfunction

    task automatic cfg_write(input logic [5:0] dw, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_dw_addr = dw; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0; cfg_be = '0;
        for (int k = 0; k < 4; k++) begin
            int ofs;
            logic [7:0] b;
            ofs = int'(dw) * 4 + k;
            b = d[8*k +: 8];
            if (be[k]) begin
                if (ofs >= 'h59 && ofs <= 'h5F) m_attr[ofs - 'h59] = b;
                if (ofs == 'h72) begin
                    m_close = b[5];
                    m_gen   = b[3];
                    if (b[4]) m_lock = 1'b1;
                    m_open  = b[6] && !m_lock;
                end
            end
        end
    endtask

    task automatic cfg_read(input logic [5:0] dw, output logic [31:0] d);
        @(negedge clk);
        cfg_dw_addr = dw;
        #1 d = cfg_rdata;
    endtask

    task automatic check_segs(input string tag);
        logic [12:0] er, ew;
        for (int i = 0; i < 13; i++) begin
            er[i] = m_nib(i)[0];
            ew[i] = m_nib(i)[1];
        end
        check({tag, " seg_rd"}, 32'(seg_rd_dram), 32'(er));
        check({tag, " seg_wr"}, 32'(seg_wr_dram), 32'(ew));
    endtask

    task automatic check_addr(input string tag, input logic [31:0] a, input logic smm);
        @(negedge clk);
        acc_addr = a; acc_smm = smm;
        #1 check({tag, " route"}, {30'd0, acc_wr_dram, acc_rd_dram}, {30'd0, m_route(a, smm)});
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check_segs("R1 reset");
        cfg_read(6'h1C, d);
        check("R1 smram reset byte", d, 32'h0002_0000);
        check("R1 alias", 32'(win_pci_alias), 32'd1);
        check("R1 smm dram", 32'(win_smm_dram), 32'd0);
    endtask

    task automatic t_attr_pair();
        logic [31:0] d;
        cfg_write(6'h16, 4'b1110, 32'h1321_3000);
        check_segs("R2 pair 58");
        cfg_write(6'h17, 4'b1111, 32'h3210_2301);
        check_segs("R2 pair 5C");
        cfg_read(6'h17, d);
        check("R3 readback 5C", d, 32'h3210_2301);
    endtask

    task automatic t_lanes();
        logic [31:0] d;
        cfg_write(6'h17, 4'b0101, 32'h1122_3344);
        cfg_read(6'h17, d);
        check("R3 partial lanes", d, {m_attr[6], m_attr[5], m_attr[4], m_attr[3]});
        check_segs("R3 partial lanes");
        cfg_read(6'h20, d);
        check("R3 unimplemented reads 0", d, 32'h0);
    endtask

    task automatic t_ignore();
        logic [31:0] d;
        logic [12:0] r0, w0;
        r0 = seg_rd_dram; w0 = seg_wr_dram;
        cfg_write(6'h15, 4'b1111, 32'hFFFF_FFFF);
        cfg_write(6'h20, 4'b1111, 32'hFFFF_FFFF);
        cfg_write(6'h16, 4'b0001, 32'h0000_00FF);
        check("R4 seg_rd unchanged", 32'(seg_rd_dram), 32'(r0));
        check("R4 seg_wr unchanged", 32'(seg_wr_dram), 32'(w0));
        check("R4 alias unchanged", 32'(win_pci_alias), 32'd1);
        cfg_read(6'h16, d);
        check("R4 offset 58 reads 0", 32'(d[7:0]), 32'h0);
        cfg_read(6'h15, d);
        check("R10 size byte write ignored", 32'(d[31:24]), 32'd64);
    endtask

    task automatic t_size();
        logic [31:0] d;
        dram_mb = 16'd64;   cfg_read(6'h15, d); check("R10 size 64MB", 32'(d[31:24]), 32'd8);
        dram_mb = 16'd2032; cfg_read(6'h15, d); check("R10 size 2032MB", 32'(d[31:24]), 32'd254);
        dram_mb = 16'd2040; cfg_read(6'h15, d); check("R10 size 2040MB", 32'(d[31:24]), 32'd255);
        dram_mb = 16'd4096; cfg_read(6'h15, d); check("R10 size saturates", 32'(d[31:24]), 32'd255);
    endtask

    task automatic t_route();
        cfg_write(6'h16, 4'b1110, 32'h2113_1000);
        cfg_write(6'h17, 4'b1111, 32'h1302_3120);
        for (int s = 0; s < 12; s++) begin
            check_addr("R9 expansion seg", 32'hC0000 + 32'(s) * 32'h4000 + 32'h123, 1'b0);
            check_addr("R9 expansion seg end", 32'hC3FFF + 32'(s) * 32'h4000, 1'b1);
        end
        check_addr("R9 bios lo", 32'hF0000, 1'b0);
        check_addr("R9 bios hi", 32'hFFFFF, 1'b1);
        check_addr("R9 below window", 32'h9FFFF, 1'b0);
        check_addr("R9 above 1MB", 32'h100000, 1'b0);
        check_addr("R9 high", 32'h1234_5678, 1'b1);
    endtask

    task automatic t_smram();
        logic [31:0] d;
        cfg_write(6'h1C, 4'b0100, 32'h0040_0000);
        cfg_read(6'h1C, d);
        check("R5 open readback", d, 32'h0042_0000);
        check("R7 alias off when open", 32'(win_pci_alias), 32'd0);
        check_addr("R7 user window open", 32'hA0000, 1'b0);
        check_addr("R8 smm window no gen", 32'hBFFFF, 1'b1);
        cfg_write(6'h1C, 4'b0100, 32'h0028_0000);
        cfg_read(6'h1C, d);
        check("R5 close+gen readback", d, 32'h002A_0000);
        check("R7 alias on when closed", 32'(win_pci_alias), 32'd1);
        check("R8 smm dram flag", 32'(win_smm_dram), 32'd1);
        check_addr("R7 user window closed", 32'hB0000, 1'b0);
        check_addr("R8 smm window gen", 32'hA8000, 1'b1);
    endtask

    task automatic t_collide();
        logic old_rd;
        m_attr[1] = m_attr[1];
        @(negedge clk);
        acc_addr = 32'hC0000; acc_smm = 1'b0;
        #1 old_rd = acc_rd_dram;
        check("R4 lookup before write", 32'(old_rd), 32'(m_nib(1)[0]));
        @(negedge clk);
        cfg_we = 1'b1; cfg_dw_addr = 6'h16; cfg_be = 4'b0100;
        cfg_wdata = {8'h00, m_attr[1] ^ 8'h03, 16'h0000};
        #1 check("R4 lookup in write cycle sees old", 32'(acc_rd_dram), 32'(old_rd));
        @(negedge clk);
        cfg_we = 1'b0; cfg_be = '0;
        m_attr[1] = m_attr[1] ^ 8'h03;
        #1 check("R4 lookup after write sees new", 32'(acc_rd_dram), 32'(m_nib(1)[0]));
        check_segs("R4 outputs together");
    endtask

    task automatic t_lock();
        logic [31:0] d;
        cfg_write(6'h1C, 4'b0100, 32'h0050_0000);
        cfg_read(6'h1C, d);
        check("R6 lock with open stores open 0", d, 32'h0012_0000);
        check("R6 alias stays", 32'(win_pci_alias), 32'd1);
        cfg_write(6'h1C, 4'b0100, 32'h0048_0000);
        cfg_read(6'h1C, d);
        check("R6 open unwritable when sealed", d, 32'h001A_0000);
        cfg_write(6'h1C, 4'b0100, 32'h0000_0000);
        cfg_read(6'h1C, d);
        check("R6 lock sticky", d, 32'h0012_0000);
        check_addr("R6 user window stays PCI", 32'hA0000, 1'b0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int j = 0; j < 7; j++) m_attr[j] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_attr_pair();
        t_lanes();
        t_ignore();
        t_size();
        t_route();
        t_smram();
        t_collide();
        t_lock();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule